// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides whether an 8-bit microcontroller core accepts a pending reset request or a hardware interrupt, and then carries out the entry. On acceptance it captures the current program counter as the return address. It then writes that address to the stack one byte per cycle and post-decrements the stack pointer it keeps. Finally it loads the program counter with the address of the selected vector. In the accepting cycle it also reports which pending source it serviced and tells the core to clear the global interrupt enable.

No entry starts while the core holds a pending instruction skip, because the skip and the instruction after it must not be separated. The number of return-address bytes and the vector spacing are fixed when the block is elaborated.

The stack write port is a valid/ready stream. While `stk_valid_o` is high and `stk_ready_i` is low, the address and data stay unchanged and the sequencer waits. A byte counts as written only in a cycle where both signals are high. All other pins are plain level or single-cycle pulse signals.

Top module: `irq_entry_seq`

## Requirements
- R1: While `skip_i` is high, no entry is accepted, whether or not a reset request or pending sources are present.
- R2: An entry is accepted only while `gie_i` is high. A reset request takes precedence over pending hardware sources.
- R3: Among set bits of `pend_i`, the lowest index wins. In the accepting cycle `pend_clr_o` carries exactly that single bit, and it is all zero for a reset entry.
- R4: When the last byte has been written, `pc_o` becomes vector times vector size. The vector is 0 for a reset entry and the winning bit index plus 1 for a hardware source. The vector size is 2 when `LONG_VEC` is 1 and 1 otherwise.
- R5: The return PC is written as `PC_BYTES` bytes: the low byte first, then the middle byte, then the high byte. Each byte goes to address `sp_o`, and `sp_o` is then decremented by one.
- R6: `gie_clr_o` is high for exactly one cycle, the cycle in which an entry is accepted.
- R7: `busy_o` rises the cycle after acceptance and falls in the cycle `pc_o` is loaded. No new arbitration happens while it is high.
- R8: While `stk_valid_o` is high and `stk_ready_i` is low, `stk_addr_o` and `stk_data_o` hold their values and no byte is consumed.
- R9: While idle, `sp_wr_i` and `pc_wr_i` load `sp_o` and `pc_o`. These writes are ignored while busy and in the accepting cycle.
- R10: After reset, `busy_o` and `stk_valid_o` are 0, `pc_o` is 0 and `sp_o` equals `SP_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | SRC_W | Pending hardware sources |
| rst_req_i | input | 1 | Reset entry request |
| gie_i | input | 1 | Global interrupt enable |
| skip_i | input | 1 | Instruction skip pending |
| pc_wr_i | input | 1 | Core writes PC |
| pc_wdata_i | input | 8*PC_BYTES | PC write value |
| sp_wr_i | input | 1 | Core writes SP |
| sp_wdata_i | input | SP_W | SP write value |
| stk_valid_o | output | 1 | Stack byte valid |
| stk_ready_i | input | 1 | Stack byte accepted |
| stk_addr_o | output | SP_W | Stack byte address |
| stk_data_o | output | 8 | Stack byte data |
| pc_o | output | 8*PC_BYTES | Program counter |
| sp_o | output | SP_W | Stack pointer |
| busy_o | output | 1 | Entry in progress |
| gie_clr_o | output | 1 | Clear global enable pulse |
| pend_clr_o | output | SRC_W | Serviced source bit pulse |

## Verification
A wrong byte counter shows up at once as a misordered byte on `stk_data_o`. It also shows up as an early or late fall of `busy_o`, and every later entry inherits the shifted `sp_o`. A wrong latched vector is only visible in the single cycle `pc_o` is loaded, so each scenario compares `pc_o` on the cycle `busy_o` falls. Stalled pushes show whether the stack pointer and the counter advance without a handshake, because any drift appears in the next `stk_addr_o`.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PUSH = 1'b1
  } seq_state_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int SRC_W = 8,
  localparam int VEC_W = $clog2(SRC_W + 1)
) (
  input  logic [SRC_W-1:0] pend_i,
  input  logic             rst_req_i,
  input  logic             gie_i,
  input  logic             skip_i,
  input  logic             idle_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [SRC_W-1:0] clr_o
);
  logic             any_src;
  logic [VEC_W-1:0] low_idx;

  assign any_src = |pend_i;

  // lowest set index: scan downward so the smallest index is written last
  always_comb begin
    low_idx = '0;
    for (int k = SRC_W - 1; k >= 0; k--) begin
      if (pend_i[k]) low_idx = VEC_W'(k);
    end
  end

  always_comb begin
    take_o = idle_i && !skip_i && gie_i && (rst_req_i || any_src);
    vec_o  = '0;
    clr_o  = '0;
    if (take_o && !rst_req_i) begin
      vec_o = low_idx + VEC_W'(1);
      clr_o = SRC_W'(1) << low_idx;
    end
  end
endmodule

// File: rtl/irq_push_seq.sv
module irq_push_seq
  import irq_entry_pkg::*;
#(
  parameter int PC_BYTES = 2,
  localparam int PC_W  = 8 * PC_BYTES,
  localparam int CNT_W = (PC_BYTES > 1) ? $clog2(PC_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PC_W-1:0] ret_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [7:0]      data_o,
  output logic            step_o,
  output logic            done_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  ret_q;

  assign valid_o = (state_q == ST_PUSH);
  assign step_o  = valid_o && ready_i;
  assign done_o  = step_o && (cnt_q == CNT_W'(PC_BYTES - 1));
  assign data_o  = 8'(ret_q >> {cnt_q, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ret_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q <= ST_PUSH;
        cnt_q   <= '0;
        ret_q   <= ret_i;
      end
    end else if (step_o) begin
      if (done_o) state_q <= ST_IDLE;
      else        cnt_q   <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int          SRC_W    = 8,
  parameter int          PC_BYTES = 2,
  parameter bit          LONG_VEC = 1'b1,
  parameter int          SP_W     = 16,
  parameter logic [15:0] SP_INIT  = 16'h08FF,
  localparam int PC_W  = 8 * PC_BYTES,
  localparam int VEC_W = $clog2(SRC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] pend_i,
  input  logic             rst_req_i,
  input  logic             gie_i,
  input  logic             skip_i,
  input  logic             pc_wr_i,
  input  logic [PC_W-1:0]  pc_wdata_i,
  input  logic             sp_wr_i,
  input  logic [SP_W-1:0]  sp_wdata_i,
  output logic             stk_valid_o,
  input  logic             stk_ready_i,
  output logic [SP_W-1:0]  stk_addr_o,
  output logic [7:0]       stk_data_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [SP_W-1:0]  sp_o,
  output logic             busy_o,
  output logic             gie_clr_o,
  output logic [SRC_W-1:0] pend_clr_o
);
  logic             take;
  logic [VEC_W-1:0] vec_now, vec_q;
  logic [SRC_W-1:0] clr_now;
  logic             step, done;
  logic [SP_W-1:0]  sp_q;
  logic [PC_W-1:0]  pc_q;

  irq_arbiter #(.SRC_W(SRC_W)) u_arb (
    .pend_i   (pend_i),
    .rst_req_i(rst_req_i),
    .gie_i    (gie_i),
    .skip_i   (skip_i),
    .idle_i   (!busy_o),
    .take_o   (take),
    .vec_o    (vec_now),
    .clr_o    (clr_now)
  );

  irq_push_seq #(.PC_BYTES(PC_BYTES)) u_push (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(take),
    .ret_i  (pc_q),
    .ready_i(stk_ready_i),
    .valid_o(stk_valid_o),
    .data_o (stk_data_o),
    .step_o (step),
    .done_o (done)
  );

  assign busy_o     = stk_valid_o;
  assign gie_clr_o  = take;
  assign pend_clr_o = clr_now;
  assign stk_addr_o = sp_q;
  assign sp_o       = sp_q;
  assign pc_o       = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= SP_W'(SP_INIT);
      pc_q  <= '0;
      vec_q <= '0;
    end else begin
      if (take) vec_q <= vec_now;
      if (step) sp_q <= sp_q - SP_W'(1);
      else if (!busy_o && !take && sp_wr_i) sp_q <= sp_wdata_i;
      if (done) pc_q <= PC_W'(vec_q) << (LONG_VEC ? 1 : 0);
      else if (!busy_o && !take && pc_wr_i) pc_q <= pc_wdata_i;
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int SRC_W = 8,
  parameter int SP_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             skip_i,
  input logic             stk_valid_o,
  input logic             stk_ready_i,
  input logic [SP_W-1:0]  stk_addr_o,
  input logic [7:0]       stk_data_o,
  input logic [SP_W-1:0]  sp_o,
  input logic             busy_o,
  input logic             gie_clr_o,
  input logic [SRC_W-1:0] pend_clr_o
);
  p_skip_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && skip_i) |=> !busy_o);
  p_clr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr_o));
  p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid_o && stk_ready_i) |=> (sp_o == $past(sp_o) - SP_W'(1)));
  p_gie_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_o |=> (busy_o && !gie_clr_o));
  p_no_rearb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!gie_clr_o && pend_clr_o == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid_o && !stk_ready_i) |=>
      (stk_valid_o && $stable(stk_addr_o) && $stable(stk_data_o)));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.SRC_W(SRC_W), .SP_W(SP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .skip_i     (skip_i),
  .stk_valid_o(stk_valid_o),
  .stk_ready_i(stk_ready_i),
  .stk_addr_o (stk_addr_o),
  .stk_data_o (stk_data_o),
  .sp_o       (sp_o),
  .busy_o     (busy_o),
  .gie_clr_o  (gie_clr_o),
  .pend_clr_o (pend_clr_o)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int SRC_W = 8;
  localparam int PC_W  = 16;
  localparam int SP_W  = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [SRC_W-1:0] pend;
  logic             rst_req, gie, skip, pc_wr, sp_wr, rdy;
  logic [PC_W-1:0]  pc_wd;
  logic [SP_W-1:0]  sp_wd;
  logic             stk_valid, busy, gie_clr;
  logic [SP_W-1:0]  stk_addr, sp;
  logic [7:0]       stk_data;
  logic [PC_W-1:0]  pc;
  logic [SRC_W-1:0] pend_clr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .rst_req_i(rst_req), .gie_i(gie),
    .skip_i(skip), .pc_wr_i(pc_wr), .pc_wdata_i(pc_wd), .sp_wr_i(sp_wr),
    .sp_wdata_i(sp_wd), .stk_valid_o(stk_valid), .stk_ready_i(rdy),
    .stk_addr_o(stk_addr), .stk_data_o(stk_data), .pc_o(pc), .sp_o(sp),
    .busy_o(busy), .gie_clr_o(gie_clr), .pend_clr_o(pend_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_regs(input logic [PC_W-1:0] p, input logic [SP_W-1:0] s);
    @(negedge clk);
    pc_wr = 1; pc_wd = p; sp_wr = 1; sp_wd = s;
    @(negedge clk);
    pc_wr = 0; sp_wr = 0;
    chk("R9 pc load", pc, p);
    chk("R9 sp load", sp, s);
  endtask

  // one entry with ready held high; checks pulses, both bytes and the vector
  task automatic entry(input string tag, input logic [SRC_W-1:0] src, input logic rr,
                       input logic [SRC_W-1:0] exp_clr, input logic [PC_W-1:0] exp_pc);
    logic [PC_W-1:0] ret;
    logic [SP_W-1:0] s0;
    ret = pc; s0 = sp;
    pend = src; rst_req = rr; gie = 1;
    #1;
    chk({tag, " R6 gie_clr"}, gie_clr, 1);
    chk({tag, " R3 pend_clr"}, pend_clr, exp_clr);
    @(negedge clk);
    pend = 0; rst_req = 0; gie = 0;
    chk({tag, " R7 busy"}, busy, 1);
    chk({tag, " R5 addr0"}, stk_addr, s0);
    chk({tag, " R5 low byte"}, stk_data, ret[7:0]);
    @(negedge clk);
    chk({tag, " R5 addr1"}, stk_addr, s0 - 1);
    chk({tag, " R5 high byte"}, stk_data, ret[15:8]);
    @(negedge clk);
    chk({tag, " R7 busy low"}, busy, 0);
    chk({tag, " R4 new pc"}, pc, exp_pc);
    chk({tag, " R5 sp"}, sp, s0 - 2);
  endtask

  task automatic t_reset_state;
    chk("R10 busy", busy, 0);
    chk("R10 valid", stk_valid, 0);
    chk("R10 pc", pc, 0);
    chk("R10 sp", sp, 16'h08FF);
  endtask

  task automatic t_reset_entry;
    load_regs(16'hA1B2, 16'h0200);
    entry("rst", 8'b0001_0000, 1'b1, 8'h00, 16'h0000); // R2 reset wins, R4 vector 0
  endtask

  task automatic t_hw_single;
    load_regs(16'h3456, 16'h0300);
    entry("hw3", 8'b0000_1000, 1'b0, 8'h08, 16'h0008); // R4 (3+1)*2
  endtask

  task automatic t_lowest_wins;
    load_regs(16'h0F0E, 16'h0400);
    entry("low", 8'b1010_0100, 1'b0, 8'h04, 16'h0006); // R3 index 2
    load_regs(16'h1111, 16'h0410);
    entry("top", 8'b1000_0000, 1'b0, 8'h80, 16'h0010); // R4 (7+1)*2
  endtask

  task automatic t_blocked;
    @(negedge clk);
    pend = 8'h01; rst_req = 1; gie = 1; skip = 1; // R1
    repeat (3) @(negedge clk);
    chk("R1 skip blocks", busy, 0);
    skip = 0; gie = 0; // R2
    repeat (3) @(negedge clk);
    chk("R2 gie blocks", busy, 0);
    chk("R2 gie blocks pulse", gie_clr, 0);
    pend = 0; rst_req = 0;
  endtask

  task automatic t_backpressure;
    logic [7:0] d0;
    load_regs(16'hC3D4, 16'h0500);
    pend = 8'h02; gie = 1; rdy = 0;
    @(negedge clk);
    pend = 8'h02; // still pending; R7 no re-arbitration while busy
    d0 = stk_data;
    chk("R8 first byte", d0, 8'hD4);
    sp_wr = 1; sp_wd = 16'h1234; pc_wr = 1; pc_wd = 16'h5555; // R9 ignored
    repeat (3) @(negedge clk);
    sp_wr = 0; pc_wr = 0;
    chk("R8 valid held", stk_valid, 1);
    chk("R8 addr held", stk_addr, 16'h0500);
    chk("R8 data held", stk_data, 8'hD4);
    chk("R7 no new clr", pend_clr, 8'h00);
    chk("R9 sp ignored", sp, 16'h0500);
    pend = 0; gie = 0; rdy = 1;
    @(negedge clk);
    chk("R5 byte after stall", stk_data, 8'hC3);
    @(negedge clk);
    chk("R4 stalled pc", pc, 16'h0004);
    chk("R9 pc ignored", pc, 16'h0004);
    chk("R5 sp after stall", sp, 16'h04FE);
  endtask

  initial begin
    rst_n = 0; pend = 0; rst_req = 0; gie = 0; skip = 0;
    pc_wr = 0; sp_wr = 0; pc_wd = 0; sp_wd = 0; rdy = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_reset_entry();
    t_hw_single();
    t_lowest_wins();
    t_blocked();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule